// File: doc/BRIEF.md
# RTC Alarm Comparator with Per-Field Masks

This block watches the current time of a real-time clock (seconds, minutes, hours, day of month and month, each one BCD byte) and compares it against five programmable alarm bytes. Each alarm byte has an exclude bit in its top position. A set exclude bit leaves that field out of the comparison. Setting the right exclude bits gives an alarm that fires once a minute, once an hour or once a day. With no bits set, the alarm fires on one exact second of one day in the year.

When the enabled fields start to agree with the clock, the block latches an alarm flag. The flag stays set until software reads the flags register; that read is presented to the block as a one-cycle strobe. The interrupt request is the flag gated by an interrupt-enable input. The alarm bytes can be changed only while the write-unlock input (the W bit held elsewhere) is high. The clock counters and the bus decoder sit outside this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, alarm_flag and alarm_irq are 0 and all five alarm bytes hold 0x00, so every field is enabled with value zero.
- R2: A write with wr_en=1 and wr_unlock=1 stores wr_data into the alarm byte selected by wr_addr. The addresses are 0 seconds, 1 minutes, 2 hours, 3 day of month and 4 month. The new byte takes part in the comparison from the next cycle.
- R3: A write with wr_unlock=0 leaves every alarm byte unchanged.
- R4: Bit 7 of an alarm byte excludes its field from the comparison when it is 1. When bit 7 is 0, the field agrees only if the whole alarm byte equals the matching cur_time byte. Field i occupies cur_time[8*i+7:8*i].
- R5: alarm_flag becomes 1 on the clock edge at which all enabled fields first agree, where they did not agree in the previous cycle.
- R6: While agreement persists, alarm_flag is not set again, so a flag cleared during a long match stays 0. Once set, the flag holds until it is read.
- R7: A flags_rd strobe clears alarm_flag at the next edge, unless R8 applies.
- R8: If a flags_rd strobe and a new agreement (R5) fall in the same cycle, alarm_flag ends up 1.
- R9: alarm_irq is alarm_flag AND irq_en, with no added delay.
- R10: Writes to addresses 5 to 7 change no alarm byte.
- R11: An agreement already present when reset is released does not set alarm_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_time | input | 40 | Current time, five BCD bytes, seconds in the low byte |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_unlock | input | 1 | Write unlock (W bit) |
| wr_addr | input | 3 | Alarm byte index |
| wr_data | input | 8 | Alarm byte value, bit 7 is the exclude bit |
| irq_en | input | 1 | Alarm interrupt enable |
| flags_rd | input | 1 | One-cycle strobe for a flags register read |
| alarm_flag | output | 1 | Latched alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The hardest case to reach from the ports is a flags read that lands in the same cycle as a fresh agreement. The flag must already be set, the agreement must have been broken, and then the read and the re-agreement must be applied on the same edge. The bench gets there by moving the seconds input away from the alarm value and back while it holds flags_rd high on the return edge. A second hard case is a suppressed re-trigger during a long match. The bench clears the flag while agreement persists and then confirms that the flag stays clear over several further edges.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int ALM_FIELDS  = 5;
    localparam int ALM_FIELD_W = 8;

    // Flag controller state: latched flag and last-cycle agreement
    typedef struct packed {
        logic af;
        logic prev;
    } alarm_flag_t;

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile #(
    parameter int NUM_FIELDS = 5,
    parameter int FIELD_W    = 8,
    parameter int ADDR_W     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_unlock,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [FIELD_W-1:0]            wr_data,
    output logic [NUM_FIELDS*FIELD_W-1:0] regs_flat
);

    logic [NUM_FIELDS-1:0][FIELD_W-1:0] regs_d, regs_q;
    logic                               wr_ok;

    assign wr_ok = wr_en & wr_unlock;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            // out-of-range addresses never compare equal and are dropped
            if (wr_ok && (wr_addr == ADDR_W'(i))) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_flat = regs_q;

endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int NUM_FIELDS = 5,
    parameter int FIELD_W    = 8
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] regs_flat,
    input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time,
    output logic                          match_now
);

    logic [NUM_FIELDS-1:0] field_ok;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        logic [FIELD_W-1:0] alm;
        logic [FIELD_W-1:0] now;
        assign alm = regs_flat[g*FIELD_W +: FIELD_W];
        assign now = cur_time[g*FIELD_W +: FIELD_W];
        // exclude bit forces agreement; otherwise full byte compare
        assign field_ok[g] = alm[FIELD_W-1] | (alm == now);
    end

    assign match_now = &field_ok;

endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_now,
    input  logic flags_rd,
    output logic af,
    output logic match_prev
);

    alarm_flag_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d      = st_q;
        rise      = match_now & ~st_q.prev;
        st_d.prev = match_now;
        if (rise) begin
            st_d.af = 1'b1;          // new agreement beats a read
        end else if (flags_rd) begin
            st_d.af = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.af   <= 1'b0;
            st_q.prev <= 1'b1;       // no flag for a match present at reset exit
        end else begin
            st_q <= st_d;
        end
    end

    assign af         = st_q.af;
    assign match_prev = st_q.prev;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int    NUM_FIELDS = ALM_FIELDS,
    parameter int    FIELD_W    = ALM_FIELD_W,
    localparam int   ADDR_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
    localparam int   TIME_W     = NUM_FIELDS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              wr_en,
    input  logic              wr_unlock,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic              irq_en,
    input  logic              flags_rd,
    output logic              alarm_flag,
    output logic              alarm_irq
);

    logic [TIME_W-1:0] regs_flat;
    logic              match_now;
    logic              match_prev;

    alarm_regfile #(
        .NUM_FIELDS (NUM_FIELDS),
        .FIELD_W    (FIELD_W),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_unlock (wr_unlock),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    alarm_field_cmp #(
        .NUM_FIELDS (NUM_FIELDS),
        .FIELD_W    (FIELD_W)
    ) u_cmp (
        .regs_flat (regs_flat),
        .cur_time  (cur_time),
        .match_now (match_now)
    );

    alarm_flag_ctrl u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_now  (match_now),
        .flags_rd   (flags_rd),
        .af         (alarm_flag),
        .match_prev (match_prev)
    );

    assign alarm_irq = alarm_flag & irq_en;

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
    parameter int NUM_FIELDS = 5,
    parameter int REG_BITS   = 40,
    parameter int ADDR_W     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                wr_unlock,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                irq_en,
    input logic                flags_rd,
    input logic                alarm_flag,
    input logic                alarm_irq,
    input logic                match_now,
    input logic                match_prev,
    input logic [REG_BITS-1:0] regs
);

    logic rise;
    assign rise = match_now & ~match_prev;

    p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_unlock) |=> $stable(regs));

    p_bad_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) >= NUM_FIELDS)) |=> $stable(regs));

    p_set_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> alarm_flag);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !rise) |=> !alarm_flag);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flags_rd) |=> alarm_flag);

    p_clear_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !rise) |=> !alarm_flag);

    p_match_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && rise) |=> alarm_flag);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !alarm_irq);

    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_flag);

endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(
    .NUM_FIELDS (NUM_FIELDS),
    .REG_BITS   (NUM_FIELDS * FIELD_W),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_unlock  (wr_unlock),
    .wr_addr    (wr_addr),
    .irq_en     (irq_en),
    .flags_rd   (flags_rd),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq),
    .match_now  (match_now),
    .match_prev (match_prev),
    .regs       (regs_flat)
);

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;
    localparam logic [39:0] IDLE_TIME = 40'h00_00_00_00_7F;

    // {alarm bytes month..sec, time bytes month..sec, expected agreement}
    localparam logic [80:0] VEC [NVEC] = '{
        {40'h06_21_08_15_30, 40'h06_21_08_15_30, 1'b1},
        {40'h06_21_08_15_30, 40'h07_21_08_15_30, 1'b0},
        {40'h80_80_A3_59_45, 40'h02_03_11_59_45, 1'b1},
        {40'h80_80_80_80_00, 40'h12_31_12_33_00, 1'b1},
        {40'h80_80_80_20_10, 40'h12_31_12_21_10, 1'b0},
        {40'h80_80_80_A0_10, 40'h12_31_12_05_10, 1'b1},
        {40'h11_15_80_80_59, 40'h11_16_04_30_59, 1'b0},
        {40'h12_31_23_59_58, 40'h12_31_23_59_58, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] cur_time = '0;
    logic        wr_en = 1'b0;
    logic        wr_unlock = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq_en = 1'b0;
    logic        flags_rd = 1'b0;
    logic        alarm_flag;
    logic        alarm_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_match dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_time   (cur_time),
        .wr_en      (wr_en),
        .wr_unlock  (wr_unlock),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .irq_en     (irq_en),
        .flags_rd   (flags_rd),
        .alarm_flag (alarm_flag),
        .alarm_irq  (alarm_irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic unlock, input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_unlock = unlock; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_unlock = 1'b0;
    endtask

    task automatic read_flags();
        flags_rd = 1'b1;
        step();
        flags_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        irq_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset flag", alarm_flag, 1'b0);
        rst_n = 1'b1;
        step();
        step();
        // R11: time 0 already agrees with cleared bytes at reset exit
        check("R11 no flag from match at reset exit", alarm_flag, 1'b0);
        check("R1 reset irq", alarm_irq, 1'b0);

        // R1 cleared bytes: break agreement, then restore it
        cur_time = 40'h00_00_00_00_01;
        step();
        cur_time = 40'h0;
        step();
        check("R1/R5 cleared bytes agree with zero time", alarm_flag, 1'b1);
        check("R9 irq follows flag", alarm_irq, 1'b1);

        // R7 and R6: read while agreement persists
        read_flags();
        check("R7 read clears flag", alarm_flag, 1'b0);
        step(); step(); step();
        check("R6 no re-trigger during long match", alarm_flag, 1'b0);

        // R3: locked write that would exclude seconds
        write_reg(1'b0, 3'd0, 8'h80);
        cur_time = 40'h00_00_00_00_12;
        step();
        check("R3 locked write ignored", alarm_flag, 1'b0);

        // R10: write to unmapped index 5
        write_reg(1'b1, 3'd5, 8'h80);
        step();
        check("R10 unmapped write ignored", alarm_flag, 1'b0);

        // R8: flag set, break, then read coincides with fresh agreement
        cur_time = 40'h0;
        step();
        check("R5 flag set again", alarm_flag, 1'b1);
        cur_time = 40'h00_00_00_00_12;
        step();
        check("R6 flag holds without read", alarm_flag, 1'b1);
        cur_time = 40'h0;
        flags_rd = 1'b1;
        step();
        flags_rd = 1'b0;
        check("R8 new match beats read", alarm_flag, 1'b1);

        irq_en = 1'b0;
        #1;
        check("R9 irq masked by enable", alarm_irq, 1'b0);

        // Table of patterns (R2, R4, R5, R9)
        for (int i = 0; i < NVEC; i++) begin
            logic [39:0] alm;
            logic [39:0] tim;
            logic        exp;
            {alm, tim, exp} = VEC[i];
            cur_time = IDLE_TIME;
            step();
            for (int f = 0; f < 5; f++) begin
                write_reg(1'b1, 3'(f), alm[f*8 +: 8]);
            end
            read_flags();
            irq_en = i[0];
            cur_time = tim;
            step();
            check($sformatf("R2/R4/R5 vector %0d flag", i), alarm_flag, exp);
            check($sformatf("R9 vector %0d irq", i), alarm_irq, exp & i[0]);
        end

        finish_run();
    end

endmodule